// File: doc/BRIEF.md
# Clock Frequency Window Checker

This block checks that one of up to sixteen clocks runs at the expected rate. Software picks a source and programs two tolerance limits. It enables the counter path and, after a settling delay, raises the start bit. The block then counts rising edges of the chosen clock while a fixed reference clock counts off 512 of its own cycles. When the window closes, the count is returned to the register clock domain, compared with the two limits, and reported through a done flag and a pass flag.

Three clock domains meet here: the register (system) clock, the reference clock and the selected measured clock. Start enters the reference domain through a synchroniser. The window gate enters the measured domain through a synchroniser. The done event returns through a synchroniser, and the count is sampled only after that. The implied frequency is reference / 512 × (count + 1). A parameter sets which halfword of the limit word holds the low limit.

Top module: `clkmon_top`

## Requirements
- R1: After reset, both register reads return zero.
- R2: Address 0 (control/status) stores bits [5:0] as written: bit 0 enable, bit 1 start, bits [5:2] source select. Address 1 (limits) stores all 32 bits. rdata_o is registered and shows the addressed word one clock after the address is presented. Bits [31:30] and [15:8] of the status word read zero.
- R3: Once start has been seen, edges of the selected clock are counted for exactly 512 reference cycles. No count changes while the window gate is low.
- R4: The status word bits [29:16] report the number of counted edges minus one. A source that does not toggle reads 0.
- R5: The count saturates at 16383 and does not wrap.
- R6: Status bit 6 (done) rises after the window and a drain period. The count holds steady while done is set.
- R7: Status bit 7 (pass) is 1 only if done is set and low ≤ count ≤ high. Both ends of the range count as in range.
- R8: When start is low, done, pass and the count field read zero within two clocks. When enable is low, the measured-domain counter is held cleared.
- R9: Select bits [5:2] choose which meas_clk_i bit is counted.
- R10: With LO_IN_UPPER=1 the low limit is in limit bits [31:16] and the high limit in [15:0]. With LO_IN_UPPER=0 the two halves swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock that times the window |
| meas_clk_i | input | NUM_SRC | Candidate clocks to measure |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control/status, 1 = limits |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume three things. First, the selected clock runs fast enough to pass the window gate through two flops within the drain period. Second, the select and enable bits stay fixed while start is high. Third, start stays low long enough for the reference domain to see it drop. The stimulus respects all three. Its sources run at 1/2.5, 2 and 40 times the reference rate, plus one source tied low. It changes select only with start and enable low, and it holds the clear state until the count field reads zero. The fast and idle sources give exact counts of 16383 and 0, so both limit boundaries can be hit exactly. The other sources are checked within a ±2 band around the ideal ratio.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int CNT_W = 14;
  localparam int CNT_LSB = 16;

  typedef struct packed {
    logic [3:0] sel;
    logic       start;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_RUN   = 2'd1,
    W_DRAIN = 2'd2,
    W_DONE  = 2'd3
  } win_st_e;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/clkmon_ref_window.sv
module clkmon_ref_window
  import clkmon_pkg::*;
#(
  parameter int WIN_CYC   = 512,
  parameter int DRAIN_CYC = 16
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic gate_o,
  output logic done_o
);
  localparam int CW = $clog2(WIN_CYC + DRAIN_CYC + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] DRN_LAST = CW'(DRAIN_CYC - 1);

  logic          start_s;
  win_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          gate_q, done_q;

  clkmon_sync u_start_sync (.clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(start_i), .q_o(start_s));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!start_s) begin
      st_d  = W_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        W_IDLE: begin
          st_d  = W_RUN;
          cnt_d = '0;
        end
        W_RUN: begin
          if (cnt_q == WIN_LAST) begin
            st_d  = W_DRAIN;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        W_DRAIN: begin
          if (cnt_q == DRN_LAST) st_d = W_DONE;
          else                   cnt_d = cnt_q + 1'b1;
        end
        default: st_d = W_DONE;
      endcase
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      gate_q <= (st_d == W_RUN);
      done_q <= (st_d == W_DONE);
    end
  end

  assign gate_o = gate_q;
  assign done_o = done_q;

  // R3
  win_len_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ($fell(gate_q) && $past(start_s)) |-> ($past(cnt_q) == WIN_LAST));
endmodule

// File: rtl/clkmon_edge_counter.sv
module clkmon_edge_counter
  import clkmon_pkg::*;
(
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int ACC_W = CNT_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(1) << CNT_W;

  logic             srst_n, gate_s, gate_d;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_m1;

  // asserted asynchronously, released on the measured clock
  clkmon_sync u_rst_sync  (.clk_i(clk_i), .rst_ni(arst_ni), .d_i(1'b1),   .q_o(srst_n));
  clkmon_sync u_gate_sync (.clk_i(clk_i), .rst_ni(srst_n),  .d_i(gate_i), .q_o(gate_s));

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      gate_d <= 1'b0;
      acc_q  <= '0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d)                 acc_q <= ACC_W'(1);
      else if (gate_s && (acc_q != ACC_MAX)) acc_q <= acc_q + 1'b1;
    end
  end

  assign acc_m1  = acc_q - 1'b1;
  assign count_o = (acc_q == '0) ? '0 : acc_m1[CNT_W-1:0];

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    acc_q <= ACC_MAX);

  // R3
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!srst_n)
    !gate_s |=> $stable(acc_q));
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int   NUM_SRC     = 16,
  parameter int   WIN_CYC     = 512,
  parameter int   DRAIN_CYC   = 16,
  parameter logic LO_IN_UPPER = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic [NUM_SRC-1:0] meas_clk_i,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctrl_t            ctrl_q;
  logic [31:0]      lim_q;
  logic [15:0]      lo_lim, hi_lim;
  logic             done_q, pass_q;
  logic [CNT_W-1:0] cap_q;
  logic             win_gate, win_done, done_s, done_d;
  logic             mclk, cnt_rst_n;
  logic [CNT_W-1:0] cnt_w;
  logic             in_range;
  logic [31:0]      rdata_d;

  assign mclk      = meas_clk_i[ctrl_q.sel[SEL_W-1:0]];
  assign cnt_rst_n = rst_ni & ctrl_q.en;

  generate
    if (LO_IN_UPPER) begin : g_lo_hi
      assign lo_lim = lim_q[31:16];
      assign hi_lim = lim_q[15:0];
    end else begin : g_hi_lo
      assign lo_lim = lim_q[15:0];
      assign hi_lim = lim_q[31:16];
    end
  endgenerate

  clkmon_ref_window #(.WIN_CYC(WIN_CYC), .DRAIN_CYC(DRAIN_CYC)) u_win (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ctrl_q.start),
    .gate_o   (win_gate),
    .done_o   (win_done)
  );

  clkmon_edge_counter u_cnt (
    .clk_i  (mclk),
    .arst_ni(cnt_rst_n),
    .gate_i (win_gate),
    .count_o(cnt_w)
  );

  clkmon_sync u_done_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(win_done), .q_o(done_s));

  // cnt_w is quasi-static once done has crossed
  assign in_range = ({2'b00, cnt_w} >= lo_lim) && ({2'b00, cnt_w} <= hi_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lim_q  <= '0;
      done_d <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      done_d <= done_s;
      if (wr_en_i && !addr_i) ctrl_q <= ctrl_t'(wdata_i[5:0]);
      if (wr_en_i &&  addr_i) lim_q  <= wdata_i;
      if (!ctrl_q.start) begin
        done_q <= 1'b0;
        pass_q <= 1'b0;
        cap_q  <= '0;
      end else if (done_s && !done_d) begin
        done_q <= 1'b1;
        pass_q <= in_range;
        cap_q  <= cnt_w;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i) rdata_d = lim_q;
    else begin
      rdata_d[5:0]                = ctrl_q;
      rdata_d[6]                  = done_q;
      rdata_d[7]                  = pass_q;
      rdata_d[CNT_LSB +: CNT_W]   = cap_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end

  // R7
  pass_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |-> done_q);

  // R6
  cap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q)) |-> $stable(cap_q));
endmodule

// File: tb/sim_clkmon_top.sv
`timescale 1ns/1ps
module sim_clkmon_top;
  localparam int CLK_PER = 10;
  localparam int REF_PER = 80;
  localparam int WDOG_CYC = 150000;

  logic clk = 1'b0, ref_clk = 1'b0;
  logic m1 = 1'b0, m2 = 1'b0, m3 = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic [15:0] mclk;

  always #(CLK_PER/2) clk = ~clk;
  always #(REF_PER/2) ref_clk = ~ref_clk;
  always #20  m1 = ~m1;   // 2x ref
  always #1   m2 = ~m2;   // 40x ref
  always #100 m3 = ~m3;   // 0.4x ref
  assign mclk = {12'b0, m3, m2, m1, 1'b0};

  clkmon_top #(.LO_IN_UPPER(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .meas_clk_i(mclk),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  clkmon_top #(.LO_IN_UPPER(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .meas_clk_i(mclk),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1));

  int n_vec = 0, n_err = 0;
  bit finished = 1'b0;

  // behavioural register model
  logic [31:0] m_ctrl = '0, m_lim = '0;
  logic        m_addr = 1'b0;
  logic [31:0] p_ctrl = '0, p_lim = '0;
  logic        p_start = 1'b0, pp_start = 1'b0;
  bit          p_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d (0x%h) exp=%0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && p_valid) begin
      if (m_addr) chk(rdata == p_lim, "R2 limit readback", rdata, p_lim);
      else begin
        chk(rdata[5:0] == p_ctrl[5:0], "R2 control readback", {26'b0, rdata[5:0]}, {26'b0, p_ctrl[5:0]});
        chk(rdata[31:30] == 2'b0 && rdata[15:8] == 8'b0, "R2 reserved zero", rdata, 32'h0);
        chk(!rdata[7] || rdata[6], "R7 pass without done", {30'b0, rdata[7:6]}, 32'h3);
        if (!p_start && !pp_start)
          chk(rdata[7:6] == 2'b0 && rdata[29:16] == 14'b0, "R8 cleared while start low", rdata, {26'b0, p_ctrl[5:0]});
      end
    end
    pp_start = p_start;
    p_start  = m_ctrl[1];
    p_ctrl   = m_ctrl;
    p_lim    = m_lim;
    p_valid  = rst_n;
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    m_addr = a;
    if (a) m_lim = d; else m_ctrl = {26'b0, d[5:0]};
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; m_addr = 1'b0;
  endtask

  task automatic measure(input int sel, input logic [31:0] lim,
                         output logic [31:0] st0, output logic [31:0] st1);
    bit ok;
    wr(1'b0, 32'(sel) << 2);
    ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rdata[29:16] == 14'd0) begin ok = 1'b1; break; end
    end
    chk(ok, "R8 count returns to zero", {18'b0, rdata[29:16]}, 32'd0);
    wr(1'b1, lim);
    wr(1'b0, (32'(sel) << 2) | 32'h1);
    repeat (100) @(negedge clk);
    wr(1'b0, (32'(sel) << 2) | 32'h3);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rdata[6]) begin ok = 1'b1; break; end
    end
    chk(ok, "R6 done set after window", {31'b0, rdata[6]}, 32'd1);
    repeat (4) @(negedge clk);
    st0 = rdata;
    st1 = rdata1;
  endtask

  initial begin
    #(CLK_PER * WDOG_CYC);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] s0, s1;
    int c;
    repeat (5) @(negedge clk);
    chk(rdata == 32'h0, "R1 status after reset", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdata == 32'h0, "R1 status after reset", rdata, 32'h0);
    addr = 1'b1; m_addr = 1'b1;
    @(negedge clk);
    chk(rdata == 32'h0, "R1 limits after reset", rdata, 32'h0);
    addr = 1'b0; m_addr = 1'b0;

    // R9 source 1 at 2x ref: 1024 edges -> field 1023
    measure(1, {16'd1002, 16'd1043}, s0, s1);
    c = int'(s0[29:16]);
    chk(c >= 1021 && c <= 1025, "R4 count for 2x clock", s0[29:16], 32'd1023);
    chk(s0[7] == 1'b1, "R7 pass within limits", {31'b0, s0[7]}, 32'd1);
    chk(s1[7] == 1'b0, "R10 swapped halfwords fail", {31'b0, s1[7]}, 32'd0);
    chk(s1[29:16] == s0[29:16], "R10 same count both orders", s1[29:16], s0[29:16]);

    // R8 clear after done
    wr(1'b0, 32'h1 << 2 | 32'h1);
    repeat (3) @(negedge clk);
    chk(rdata[29:6] == 24'b0, "R8 clear on start low", rdata, {26'b0, 6'h05});

    measure(1, {16'd2000, 16'd2100}, s0, s1);
    chk(s0[7] == 1'b0, "R7 below low limit fails", {31'b0, s0[7]}, 32'd0);
    chk(s1[7] == 1'b0, "R10 fail other order", {31'b0, s1[7]}, 32'd0);

    // R5 source 2 at 40x ref saturates
    measure(2, {16'd16383, 16'd16383}, s0, s1);
    chk(s0[29:16] == 14'd16383, "R5 saturated count", s0[29:16], 32'd16383);
    chk(s0[7] == 1'b1, "R7 inclusive at both limits", {31'b0, s0[7]}, 32'd1);
    measure(2, {16'd16000, 16'd16382}, s0, s1);
    chk(s0[7] == 1'b0, "R5 saturation above high limit fails", {31'b0, s0[7]}, 32'd0);
    chk(s1[7] == 1'b0, "R10 lo=16382 in lower half fails", {31'b0, s1[7]}, 32'd0);

    // R4 dead source reads zero
    measure(0, {16'd0, 16'd5}, s0, s1);
    chk(s0[29:16] == 14'd0, "R4 dead clock count", s0[29:16], 32'd0);
    chk(s0[7] == 1'b1, "R7 inclusive low limit zero", {31'b0, s0[7]}, 32'd1);
    chk(s1[7] == 1'b0, "R10 lo=5 in lower half fails", {31'b0, s1[7]}, 32'd0);
    measure(0, {16'd1, 16'd5}, s0, s1);
    chk(s0[7] == 1'b0, "R7 count below low limit", {31'b0, s0[7]}, 32'd0);

    // R3 source 3 at 0.4x ref: 204.8 edges
    measure(3, {16'd190, 16'd215}, s0, s1);
    c = int'(s0[29:16]);
    chk(c >= 201 && c <= 206, "R3 window length slow clock", s0[29:16], 32'd203);
    chk(s0[7] == 1'b1, "R9 slow source passes", {31'b0, s0[7]}, 32'd1);

    wr(1'b0, 32'h0);
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule